// File: doc/BRIEF.md
# Serial Port Configuration and Interrupt Register Block

This block is the software-visible face of an asynchronous serial port. It sits on a simple 32-bit bus that has separate write and read strobes, and it decodes a small set of word-aligned registers. The receiver and transmitter engines are separate blocks. The bus has no wait states.

The block turns control-register writes into one-cycle command strobes for those engines. It holds their mode, baud divisor and character-match settings, and it presents their status flags to software. It also keeps the interrupt enable mask and drives one interrupt line.

The mode, divisor and match settings can be locked against stray writes. The lock is a protection enable that only changes when a write carries a fixed 24-bit key. A write attempted while the lock is on leaves a sticky violation mark. The mask cannot be written directly: software sets mask bits through one register and clears them through another.

Top module: `sercfg_regs`

## Requirements
- R1: After reset, the following are all zero: mode, divisor and match outputs, interrupt mask, interrupt line, command strobes, protection enable, violation flag and read data.
- R2: A write to offset 0x00 drives `ctrl_pulse` with the written data ANDed with 0x11FC, for exactly the one cycle after the write. The bits are: 2 receiver reset, 3 transmitter reset, 4/5 receive on/off, 6/7 transmit on/off, 8 status reset, 12 request clear.
- R3: When unlocked, writes store masked values that read back and appear on the outputs: offset 0x04 mode with mask 0xDE10, offset 0x20 divisor with mask 0xFFFF, offset 0x24 match with mask 0xFF50FF.
- R4: A 1 written at offset 0x08 sets that mask bit, and a 1 written at offset 0x0C clears it. Only bits 0,1,5,6,7,9,15 (0x82E3) exist. The mask reads at offset 0x10.
- R5: A read of offset 0x14 returns the status input ANDed with 0x82E3.
- R6: One cycle after the status and mask change, `irq` equals the OR of (status AND mask).
- R7: A write at offset 0xE4 updates the protection enable from bit 0 only when bits 31:8 equal 0x554152; any other key leaves it unchanged. Offset 0xE4 reads bit 0 enable, bit 1 violation, and zero elsewhere, so the key always reads as zero.
- R8: While protection is on, writes to offsets 0x04, 0x20 and 0x24 change nothing and set the violation flag. The flag stays set until reset, and other registers stay writable.
- R9: Reads of write-only offsets (0x00, 0x08, 0x0C, 0x1C) and unmapped offsets return zero. Writes to read-only offsets (0x10, 0x14, 0x18) change nothing.
- R10: A read of offset 0x18 returns the received character zero-extended. A write to offset 0x1C places bits 7:0 on `tx_char` and pulses `tx_load` for one cycle.
- R11: Read data is valid only in the cycle after the read strobe and is zero otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_addr | input | ADDR_W | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| stat_flags | input | 32 | Status flags from the serial engines |
| rx_char | input | CHAR_W | Last received character |
| ctrl_pulse | output | 13 | One-cycle command strobes |
| mode_cfg | output | 16 | Mode setting |
| div_cfg | output | DIV_W | Baud divisor |
| cmp_cfg | output | 24 | Character match setting |
| tx_char | output | CHAR_W | Character to transmit |
| tx_load | output | 1 | Transmit character strobe |
| irq | output | 1 | Interrupt request |
| wp_en | output | 1 | Protection enable |
| wp_viol | output | 1 | Sticky protection violation |

## Verification
Every result comes from a register, so each one is due exactly one edge after its cause:
- Command strobes, transmit strobes and stored settings appear in the cycle after the write strobe.
- Read data appears in the cycle after the read strobe and returns to zero one cycle later.
- The interrupt line follows a status or mask change by one edge.

The bench drives on falling edges and samples on the next falling edge, so the observation point sits half a period after the edge that should produce the result. Expected read values are queued when the read is issued, and a monitor pops them in the cycle after the registered strobe.

// File: rtl/sercfg_pkg.sv
package sercfg_pkg;

  localparam logic [7:0] OFS_CTRL  = 8'h00;
  localparam logic [7:0] OFS_MODE  = 8'h04;
  localparam logic [7:0] OFS_IEN   = 8'h08;
  localparam logic [7:0] OFS_IDIS  = 8'h0C;
  localparam logic [7:0] OFS_IMASK = 8'h10;
  localparam logic [7:0] OFS_STAT  = 8'h14;
  localparam logic [7:0] OFS_RXD   = 8'h18;
  localparam logic [7:0] OFS_TXD   = 8'h1C;
  localparam logic [7:0] OFS_DIV   = 8'h20;
  localparam logic [7:0] OFS_CMP   = 8'h24;
  localparam logic [7:0] OFS_PROT  = 8'hE4;

  localparam logic [31:0] MSK_CTRL = 32'h0000_11FC;
  localparam logic [31:0] MSK_MODE = 32'h0000_DE10;
  localparam logic [31:0] MSK_IRQ  = 32'h0000_82E3;
  localparam logic [31:0] MSK_CMP  = 32'h00FF_50FF;

  localparam logic [23:0] PROT_KEY = 24'h554152;

  typedef struct packed {
    logic ctrl;
    logic mode;
    logic ien;
    logic idis;
    logic imask;
    logic stat;
    logic rxd;
    logic txd;
    logic div;
    logic cmp;
    logic prot;
  } sel_t;

endpackage

// File: rtl/sercfg_decode.sv
module sercfg_decode
  import sercfg_pkg::*;
#(
  parameter int unsigned ADDR_W = 8
) (
  input  logic [ADDR_W-1:0] addr,
  output sel_t              sel
);

  always_comb begin
    sel       = '0;
    sel.ctrl  = (addr == ADDR_W'(OFS_CTRL));
    sel.mode  = (addr == ADDR_W'(OFS_MODE));
    sel.ien   = (addr == ADDR_W'(OFS_IEN));
    sel.idis  = (addr == ADDR_W'(OFS_IDIS));
    sel.imask = (addr == ADDR_W'(OFS_IMASK));
    sel.stat  = (addr == ADDR_W'(OFS_STAT));
    sel.rxd   = (addr == ADDR_W'(OFS_RXD));
    sel.txd   = (addr == ADDR_W'(OFS_TXD));
    sel.div   = (addr == ADDR_W'(OFS_DIV));
    sel.cmp   = (addr == ADDR_W'(OFS_CMP));
    sel.prot  = (addr == ADDR_W'(OFS_PROT));
  end

endmodule

// File: rtl/sercfg_wprot.sv
module sercfg_wprot #(
  parameter int unsigned       KEY_W = 24,
  parameter logic [KEY_W-1:0]  KEY   = 24'h554152
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        prot_we,
  input  logic [31:0] wdata,
  input  logic        cfg_try,
  output logic        cfg_ok,
  output logic        wp_en,
  output logic        wp_viol
);

  localparam int unsigned KEY_LSB = 32 - KEY_W;

  logic key_hit;

  assign key_hit = (wdata[31:KEY_LSB] == KEY);
  assign cfg_ok  = cfg_try & ~wp_en;

  always_ff @(posedge clk) begin
    if (rst) begin
      wp_en   <= 1'b0;
      wp_viol <= 1'b0;
    end else begin
      if (prot_we && key_hit) begin
        wp_en <= wdata[0];
      end
      if (cfg_try && wp_en) begin
        wp_viol <= 1'b1;
      end
    end
  end

endmodule

// File: rtl/sercfg_irqmask.sv
module sercfg_irqmask #(
  parameter int unsigned  W    = 32,
  parameter logic [W-1:0] IMPL = 32'h0000_82E3
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         set_we,
  input  logic         clr_we,
  input  logic [W-1:0] wdata,
  input  logic [W-1:0] status,
  output logic [W-1:0] mask,
  output logic         irq
);

  logic [W-1:0] set_bits;
  logic [W-1:0] clr_bits;
  logic [W-1:0] hit;

  assign set_bits = set_we ? (wdata & IMPL) : '0;
  assign clr_bits = clr_we ? wdata : '0;

  genvar gi;
  generate
    for (gi = 0; gi < W; gi++) begin : g_bit
      if (IMPL[gi]) begin : g_live
        always_ff @(posedge clk) begin
          if (rst) mask[gi] <= 1'b0;
          else     mask[gi] <= (mask[gi] | set_bits[gi]) & ~clr_bits[gi];
        end
        assign hit[gi] = status[gi] & mask[gi];
      end else begin : g_void
        assign mask[gi] = 1'b0;
        assign hit[gi]  = 1'b0;
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) irq <= 1'b0;
    else     irq <= |hit;
  end

endmodule

// File: rtl/sercfg_regs.sv
module sercfg_regs
  import sercfg_pkg::*;
#(
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned DIV_W  = 16,
  parameter int unsigned CHAR_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  input  logic [31:0]       stat_flags,
  input  logic [CHAR_W-1:0] rx_char,
  output logic [12:0]       ctrl_pulse,
  output logic [15:0]       mode_cfg,
  output logic [DIV_W-1:0]  div_cfg,
  output logic [23:0]       cmp_cfg,
  output logic [CHAR_W-1:0] tx_char,
  output logic              tx_load,
  output logic              irq,
  output logic              wp_en,
  output logic              wp_viol
);

  localparam int unsigned CMD_W = 13;
  localparam int unsigned MODE_W = 16;
  localparam int unsigned CMP_W = 24;

  sel_t        sel;
  logic        cfg_try;
  logic        cfg_ok;
  logic [31:0] mask_q;
  logic [31:0] rd_mux;

  sercfg_decode #(.ADDR_W(ADDR_W)) u_dec (
    .addr (bus_addr),
    .sel  (sel)
  );

  assign cfg_try = bus_wr & (sel.mode | sel.div | sel.cmp);

  sercfg_wprot #(.KEY_W(24), .KEY(PROT_KEY)) u_wp (
    .clk     (clk),
    .rst     (rst),
    .prot_we (bus_wr & sel.prot),
    .wdata   (bus_wdata),
    .cfg_try (cfg_try),
    .cfg_ok  (cfg_ok),
    .wp_en   (wp_en),
    .wp_viol (wp_viol)
  );

  sercfg_irqmask #(.W(32), .IMPL(MSK_IRQ)) u_irq (
    .clk    (clk),
    .rst    (rst),
    .set_we (bus_wr & sel.ien),
    .clr_we (bus_wr & sel.idis),
    .wdata  (bus_wdata),
    .status (stat_flags),
    .mask   (mask_q),
    .irq    (irq)
  );

  // command strobes: live for one cycle after a control write
  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_pulse <= '0;
      tx_load    <= 1'b0;
    end else begin
      ctrl_pulse <= (bus_wr && sel.ctrl) ? CMD_W'(bus_wdata & MSK_CTRL) : '0;
      tx_load    <= bus_wr & sel.txd;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      tx_char <= '0;
    end else if (bus_wr && sel.txd) begin
      tx_char <= bus_wdata[CHAR_W-1:0];
    end
  end

  // lockable configuration
  always_ff @(posedge clk) begin
    if (rst) begin
      mode_cfg <= '0;
      div_cfg  <= '0;
      cmp_cfg  <= '0;
    end else if (cfg_ok) begin
      if (sel.mode) mode_cfg <= MODE_W'(bus_wdata & MSK_MODE);
      if (sel.div)  div_cfg  <= bus_wdata[DIV_W-1:0];
      if (sel.cmp)  cmp_cfg  <= CMP_W'(bus_wdata & MSK_CMP);
    end
  end

  always_comb begin
    rd_mux = '0;
    unique case (1'b1)
      sel.mode:  rd_mux = 32'(mode_cfg);
      sel.imask: rd_mux = mask_q;
      sel.stat:  rd_mux = stat_flags & MSK_IRQ;
      sel.rxd:   rd_mux = 32'(rx_char);
      sel.div:   rd_mux = 32'(div_cfg);
      sel.cmp:   rd_mux = 32'(cmp_cfg);
      sel.prot:  rd_mux = {30'b0, wp_viol, wp_en};
      default:   rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)         bus_rdata <= '0;
    else if (bus_rd) bus_rdata <= rd_mux;
    else             bus_rdata <= '0;
  end

endmodule

// File: rtl/sercfg_chk.sv
module sercfg_chk #(
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned DIV_W  = 16
) (
  input logic              clk,
  input logic              rst,
  input logic              bus_wr,
  input logic              bus_rd,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [31:0]       bus_wdata,
  input logic [31:0]       bus_rdata,
  input logic [12:0]       ctrl_pulse,
  input logic [15:0]       mode_cfg,
  input logic [DIV_W-1:0]  div_cfg,
  input logic [23:0]       cmp_cfg,
  input logic              tx_load,
  input logic              irq,
  input logic              wp_en,
  input logic              wp_viol,
  input logic [31:0]       mask_w
);

  AST_CTRL_FROM_WRITE: assert property (@(posedge clk) disable iff (rst)
    (ctrl_pulse != '0) |-> $past(bus_wr && bus_addr == ADDR_W'(8'h00))); // R2

  AST_TX_FROM_WRITE: assert property (@(posedge clk) disable iff (rst)
    tx_load |-> $past(bus_wr && bus_addr == ADDR_W'(8'h1C))); // R10

  AST_CFG_FROZEN: assert property (@(posedge clk) disable iff (rst)
    wp_en |=> ($stable(mode_cfg) && $stable(div_cfg) && $stable(cmp_cfg))); // R8

  AST_VIOL_STICKY: assert property (@(posedge clk) disable iff (rst)
    wp_viol |=> wp_viol); // R8

  AST_PROT_NEEDS_KEY: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && wp_en != $past(wp_en)) |->
      $past(bus_wr && bus_addr == ADDR_W'(8'hE4) && bus_wdata[31:8] == 24'h554152)); // R7

  AST_MASK_SET_SRC: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && (mask_w & ~$past(mask_w)) != '0) |->
      $past(bus_wr && bus_addr == ADDR_W'(8'h08))); // R4

  AST_IRQ_NEEDS_MASK: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(mask_w) == '0) |-> !irq); // R6

  AST_RDATA_IDLE: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(bus_rd)) |-> bus_rdata == '0); // R11

endmodule

bind sercfg_regs sercfg_chk #(.ADDR_W(ADDR_W), .DIV_W(DIV_W)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .bus_wr     (bus_wr),
  .bus_rd     (bus_rd),
  .bus_addr   (bus_addr),
  .bus_wdata  (bus_wdata),
  .bus_rdata  (bus_rdata),
  .ctrl_pulse (ctrl_pulse),
  .mode_cfg   (mode_cfg),
  .div_cfg    (div_cfg),
  .cmp_cfg    (cmp_cfg),
  .tx_load    (tx_load),
  .irq        (irq),
  .wp_en      (wp_en),
  .wp_viol    (wp_viol),
  .mask_w     (mask_q)
);

// File: tb/sercfg_regs_tb.sv
`timescale 1ns/1ps
module sercfg_regs_tb;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_wr = 1'b0;
  logic        bus_rd = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [31:0] stat_flags = '0;
  logic [7:0]  rx_char = '0;
  logic [12:0] ctrl_pulse;
  logic [15:0] mode_cfg;
  logic [15:0] div_cfg;
  logic [23:0] cmp_cfg;
  logic [7:0]  tx_char;
  logic        tx_load;
  logic        irq;
  logic        wp_en;
  logic        wp_viol;

  int n_chk = 0;
  int n_err = 0;
  bit done = 0;
  logic rd_seen = 1'b0;
  logic [31:0] exp_q[$];
  string       tag_q[$];

  always #10 clk = ~clk;

  sercfg_regs u_dut (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .stat_flags(stat_flags), .rx_char(rx_char), .ctrl_pulse(ctrl_pulse),
    .mode_cfg(mode_cfg), .div_cfg(div_cfg), .cmp_cfg(cmp_cfg),
    .tx_char(tx_char), .tx_load(tx_load), .irq(irq),
    .wp_en(wp_en), .wp_viol(wp_viol)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic bus_write(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  // driver: issues a read and queues the value the monitor must see
  task automatic bus_read(input logic [7:0] a, input logic [31:0] exp, input string tag);
    @(negedge clk);
    bus_rd = 1'b1; bus_addr = a;
    exp_q.push_back(exp);
    tag_q.push_back(tag);
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  always @(posedge clk) rd_seen <= bus_rd;

  // monitor: read data is due one edge after the strobe
  always @(negedge clk) begin
    if (rd_seen) begin
      if (exp_q.size() == 0) begin
        n_chk++; n_err++;
        $display("FAIL R11 unexpected read result actual=%h expected=none", bus_rdata);
      end else begin
        chk(tag_q.pop_front(), bus_rdata, exp_q.pop_front());
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_err++;
      $display("FAIL R11 watchdog actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk("R1 mode", 32'(mode_cfg), 0);
    chk("R1 div", 32'(div_cfg), 0);
    chk("R1 cmp", 32'(cmp_cfg), 0);
    chk("R1 irq/wp/viol", {29'b0, irq, wp_en, wp_viol}, 0);
    chk("R1 pulse", 32'(ctrl_pulse), 0);
    chk("R1 rdata", bus_rdata, 0);
    bus_read(8'h10, 32'h0, "R1 mask read");
    bus_read(8'hE4, 32'h0, "R1 prot read");

    // R2 control strobes
    bus_write(8'h00, 32'hFFFF_FFFF);
    chk("R2 pulse all", 32'(ctrl_pulse), 32'h11FC);
    @(negedge clk);
    chk("R2 pulse ends", 32'(ctrl_pulse), 0);
    bus_write(8'h00, 32'h0000_0004);
    chk("R2 rx reset bit", 32'(ctrl_pulse), 32'h4);

    // R3 masked configuration
    bus_write(8'h04, 32'hFFFF_FFFF);
    chk("R3 mode out", 32'(mode_cfg), 32'hDE10);
    bus_read(8'h04, 32'hDE10, "R3 mode read");
    bus_write(8'h20, 32'h1234_ABCD);
    chk("R3 div out", 32'(div_cfg), 32'hABCD);
    bus_read(8'h20, 32'hABCD, "R3 div read");
    bus_write(8'h24, 32'hFFFF_FFFF);
    bus_read(8'h24, 32'h00FF_50FF, "R3 cmp read");

    // R4 mask set/clear
    bus_write(8'h08, 32'hFFFF_FFFF);
    bus_read(8'h10, 32'h82E3, "R4 mask after set");
    bus_write(8'h0C, 32'h0000_0003);
    bus_read(8'h10, 32'h82E0, "R4 mask after clear");

    // R9 write-only / unmapped reads, read-only writes
    bus_read(8'h00, 32'h0, "R9 ctrl read");
    bus_read(8'h08, 32'h0, "R9 enable read");
    bus_read(8'h0C, 32'h0, "R9 disable read");
    bus_read(8'h1C, 32'h0, "R9 txd read");
    bus_read(8'h30, 32'h0, "R9 unmapped read");
    bus_write(8'h10, 32'h0000_0000);
    bus_read(8'h10, 32'h82E0, "R9 mask unchanged");

    // R5 status
    stat_flags = 32'hFFFF_FFFF;
    bus_read(8'h14, 32'h82E3, "R5 status read");

    // R6 interrupt
    @(negedge clk);
    stat_flags = 32'h0000_0001;
    repeat (2) @(negedge clk);
    chk("R6 masked status", 32'(irq), 0);
    stat_flags = 32'h0000_0020;
    @(negedge clk);
    chk("R6 enabled status", 32'(irq), 1);
    bus_write(8'h0C, 32'h0000_0020);
    @(negedge clk);
    chk("R6 after mask clear", 32'(irq), 0);
    stat_flags = '0;

    // R10 character path
    rx_char = 8'hA5;
    bus_read(8'h18, 32'h0000_00A5, "R10 rx read");
    @(negedge clk);
    chk("R11 rdata idle", bus_rdata, 0);
    bus_write(8'h1C, 32'h0000_015A);
    chk("R10 tx char", 32'(tx_char), 32'h5A);
    chk("R10 tx load", 32'(tx_load), 1);
    @(negedge clk);
    chk("R10 tx load ends", 32'(tx_load), 0);

    // R7 protection key
    bus_write(8'hE4, 32'h1234_5601);
    chk("R7 bad key", 32'(wp_en), 0);
    bus_write(8'hE4, 32'h5541_5201);
    chk("R7 good key", 32'(wp_en), 1);
    bus_read(8'hE4, 32'h1, "R7 prot read");

    // R8 locked writes
    bus_write(8'h04, 32'h0);
    chk("R8 mode held", 32'(mode_cfg), 32'hDE10);
    chk("R8 viol set", 32'(wp_viol), 1);
    bus_write(8'h20, 32'h0);
    bus_write(8'h24, 32'h0);
    bus_read(8'h20, 32'hABCD, "R8 div held");
    bus_read(8'h24, 32'h00FF_50FF, "R8 cmp held");
    bus_read(8'hE4, 32'h3, "R8 viol readback");
    bus_write(8'h00, 32'h0000_1000);
    chk("R8 ctrl still live", 32'(ctrl_pulse), 32'h1000);
    bus_write(8'hE4, 32'h5541_5200);
    chk("R8 unlock", 32'(wp_en), 0);
    chk("R8 viol sticky", 32'(wp_viol), 1);
    bus_write(8'h04, 32'h0000_0010);
    chk("R8 mode after unlock", 32'(mode_cfg), 32'h10);

    repeat (3) @(negedge clk);
    chk("R11 queue drained", 32'(exp_q.size()), 0);
    done = 1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

endmodule